// File: doc/BRIEF.md
# Delay-Compensated Bit Error Comparator

This block sits at the end of a serial link test loop. It compares the reference bits a test transmitter sends with the bits a receiver recovers. The transmitter's data bit and its one-cycle bit strobe each pass through their own delay line. The line's tap is chosen at run time, so the reference can be lined up with the round-trip latency of the link under test. A matched bit is a cycle in which the delayed reference strobe and the receive strobe are both high and the delayed reference bit equals the recovered bit. Matched bits are counted in a four-digit decimal (BCD) counter.

A burst controller watches the transmitter's running bit count, which arrives as an input. When that count reaches the configured burst length, the controller does three things in one clock edge. It copies the match count into a display register. It decides whether the link is in sync by testing whether the match count is strictly greater than a BCD threshold. It pulses two clear strobes: one resets the internal match counter and the other tells the external transmit bit counter to restart. Display decoding is outside this block.

Top module: `ber_delay_comparator`

## Requirements
- R1: A match is counted only in a cycle where the reference strobe, delayed by `delay_sel`+1 clock cycles, is high together with `rx_strobe`. With the delay misaligned to the link latency, no matches accumulate.
- R2: A cycle with both strobes high counts only if the delayed reference bit equals `rx_nrz`. Flipped receive bits are not counted.
- R3: Asynchronous reset clears both delay lines, the match counter, the display register and the sync flag. Once reset is released, a receive strobe with no transmitted history produces no match.
- R4: `match_count` is four BCD digits with bits [3:0] as the units digit. Each digit stays in 0..9, and an increment past 9 carries into the next digit.
- R5: An increment from 16'h9999 gives 16'h0000.
- R6: `match_clr` and `bitcnt_clr` are high together for exactly one cycle. That cycle is the first cycle in which `tx_bit_count` equals the burst length; the clears do not repeat while the count stays equal.
- R7: At the clock edge that ends the clear cycle, `disp_count` loads the current match count and the match counter returns to zero. A clear takes priority over a match in the same cycle.
- R8: At that same edge, `in_sync` is set to 1 if the match count is strictly greater than the BCD threshold and to 0 otherwise, so a count equal to the threshold gives 0.
- R9: Between burst ends, `disp_count` and `in_sync` hold their values while matches keep accumulating.
- R10: A `tx_bit_count` value other than the burst length causes no clear pulse and leaves the display and the match count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Asynchronous reset, active high |
| tx_nrz | input | 1 | Reference data bit from the transmitter |
| tx_strobe | input | 1 | One-cycle strobe marking a new reference bit |
| rx_nrz | input | 1 | Recovered data bit |
| rx_strobe | input | 1 | One-cycle strobe marking a recovered bit |
| delay_sel | input | DLY_N | Delay line tap; delay is delay_sel+1 cycles |
| tx_bit_count | input | CNT_P | Running count of transmitted bits |
| match_clr | output | 1 | Burst-end pulse, clears the match counter |
| bitcnt_clr | output | 1 | Burst-end pulse for the external bit counter |
| in_sync | output | 1 | Last burst exceeded the sync threshold |
| disp_count | output | 16 | BCD match count latched at the last burst end |
| match_count | output | 16 | Live BCD match count |

## Verification
The embedded properties are checked on every clock. They cover the BCD digit range and the 9999 wrap of the counter, that a clear always leaves zero, that the clear pulse never lasts two cycles, that the display loads the prior match count, and that the display and sync flag stay frozen between burst ends. Other behaviour depends on the stimulus and is shown only by the bench scenarios. These are the delay alignment against several link latencies, the rejection of corrupted bits, the strict "greater than" against a count equal to the threshold, and the absence of any effect from non-matching bit counts.

// File: rtl/berc_pkg.sv
package berc_pkg;
  localparam int BCD_DIGITS = 4;
  localparam int BCD_W      = 4 * BCD_DIGITS;

  // Decimal increment of a packed BCD word; wraps all-nines to zero.
  function automatic logic [BCD_W-1:0] bcd_inc(input logic [BCD_W-1:0] v);
    logic [BCD_W-1:0] r;
    logic             carry;
    r     = v;
    carry = 1'b1;
    for (int d = 0; d < BCD_DIGITS; d++) begin
      if (carry) begin
        if (v[4*d +: 4] == 4'd9) begin
          r[4*d +: 4] = 4'd0;
        end else begin
          r[4*d +: 4] = v[4*d +: 4] + 4'd1;
          carry       = 1'b0;
        end
      end
    end
    return r;
  endfunction

  // Digit-wise magnitude compare, most significant digit first.
  function automatic logic bcd_gt(input logic [BCD_W-1:0] a, input logic [BCD_W-1:0] b);
    for (int d = BCD_DIGITS - 1; d >= 0; d--) begin
      if (a[4*d +: 4] != b[4*d +: 4]) return (a[4*d +: 4] > b[4*d +: 4]);
    end
    return 1'b0;
  endfunction
endpackage

// File: rtl/tap_delay_line.sv
module tap_delay_line #(
  parameter int N = 8,
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  input  logic [N-1:0] tap_sel,
  output logic [W-1:0] dout
);
  localparam int DEPTH = 1 << N;

  logic [W-1:0] stage [DEPTH];

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) stage[i] <= '0;
    end else begin
      stage[0] <= din;
      for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
    end
  end

  assign dout = stage[tap_sel];
endmodule

// File: rtl/bcd_match_counter.sv
module bcd_match_counter
  import berc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             match_evt,
  input  logic             clr,
  output logic [BCD_W-1:0] count
);
  logic [BCD_W-1:0] count_q;

  always_ff @(posedge clk or posedge rst) begin
    if (rst)            count_q <= '0;
    else if (clr)       count_q <= '0;
    else if (match_evt) count_q <= bcd_inc(count_q);
  end

  assign count = count_q;

  logic digits_ok;
  always_comb begin
    digits_ok = 1'b1;
    for (int d = 0; d < BCD_DIGITS; d++)
      if (count_q[4*d +: 4] > 4'd9) digits_ok = 1'b0;
  end

  AST_BCD_DIGITS: assert property (@(posedge clk) disable iff (rst) digits_ok); // R4
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst) clr |=> (count_q == '0)); // R7
  AST_INC_MOVES: assert property (@(posedge clk) disable iff (rst) (match_evt && !clr) |=> (count_q != $past(count_q))); // R4
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst) (match_evt && !clr && count_q == 16'h9999) |=> (count_q == '0)); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst) (!match_evt && !clr) |=> $stable(count_q)); // R10
endmodule

// File: rtl/burst_sync_ctrl.sv
module burst_sync_ctrl
  import berc_pkg::*;
#(
  parameter int               CNT_P       = 10,
  parameter int               BURST_LEN   = 101,
  parameter logic [BCD_W-1:0] SYNC_THRESH = 16'h0055
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_P-1:0] tx_bit_count,
  input  logic [BCD_W-1:0] match_count,
  output logic             burst_end,
  output logic             in_sync,
  output logic [BCD_W-1:0] disp_count
);
  localparam logic [CNT_P-1:0] BURST_CODE = BURST_LEN[CNT_P-1:0];

  logic hit, hit_q;
  assign hit       = (tx_bit_count == BURST_CODE);
  assign burst_end = hit && !hit_q;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      hit_q      <= 1'b0;
      in_sync    <= 1'b0;
      disp_count <= '0;
    end else begin
      hit_q <= hit;
      if (burst_end) begin
        disp_count <= match_count;
        in_sync    <= bcd_gt(match_count, SYNC_THRESH);
      end
    end
  end

  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (rst) burst_end |=> !burst_end); // R6
  AST_DISP_LOAD: assert property (@(posedge clk) disable iff (rst) burst_end |=> (disp_count == $past(match_count))); // R7
  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (rst) !burst_end |=> ($stable(disp_count) && $stable(in_sync))); // R9
endmodule

// File: rtl/ber_delay_comparator.sv
module ber_delay_comparator
  import berc_pkg::*;
#(
  parameter int               DLY_N       = 8,
  parameter int               CNT_P       = 10,
  parameter int               BURST_LEN   = 101,
  parameter logic [BCD_W-1:0] SYNC_THRESH = 16'h0055
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_nrz,
  input  logic             tx_strobe,
  input  logic             rx_nrz,
  input  logic             rx_strobe,
  input  logic [DLY_N-1:0] delay_sel,
  input  logic [CNT_P-1:0] tx_bit_count,
  output logic             match_clr,
  output logic             bitcnt_clr,
  output logic             in_sync,
  output logic [BCD_W-1:0] disp_count,
  output logic [BCD_W-1:0] match_count
);
  localparam int LANES = 2;  // lane 0: data, lane 1: strobe

  logic [LANES-1:0] ref_in, ref_dly;
  assign ref_in = {tx_strobe, tx_nrz};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    tap_delay_line #(.N(DLY_N), .W(1)) u_dly (
      .clk     (clk),
      .rst     (rst),
      .din     (ref_in[g]),
      .tap_sel (delay_sel),
      .dout    (ref_dly[g])
    );
  end

  logic match_evt, burst_end;
  assign match_evt = ref_dly[1] && rx_strobe && (ref_dly[0] == rx_nrz);

  bcd_match_counter u_cnt (
    .clk       (clk),
    .rst       (rst),
    .match_evt (match_evt),
    .clr       (burst_end),
    .count     (match_count)
  );

  burst_sync_ctrl #(
    .CNT_P       (CNT_P),
    .BURST_LEN   (BURST_LEN),
    .SYNC_THRESH (SYNC_THRESH)
  ) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .tx_bit_count (tx_bit_count),
    .match_count  (match_count),
    .burst_end    (burst_end),
    .in_sync      (in_sync),
    .disp_count   (disp_count)
  );

  assign match_clr  = burst_end;
  assign bitcnt_clr = burst_end;

  AST_NO_RX_NO_COUNT: assert property (@(posedge clk) disable iff (rst) (!rx_strobe && !burst_end) |=> $stable(match_count)); // R1
  AST_CLR_PAIR: assert property (@(posedge clk) disable iff (rst) match_clr |=> !bitcnt_clr); // R6
endmodule

// File: tb/sim_ber_delay_comparator.sv
`timescale 1ns/1ps
module sim_ber_delay_comparator;
  localparam int N  = 3;
  localparam int P  = 10;
  localparam int BL = 5;
  localparam logic [15:0] TH = 16'h0003;

  logic clk = 1'b0, rst = 1'b1;
  logic tx_nrz = 0, tx_strobe = 0, rx_nrz = 0, rx_strobe = 0;
  logic [N-1:0] delay_sel = '0;
  logic [P-1:0] tx_bit_count = '0;
  logic match_clr, bitcnt_clr, in_sync;
  logic [15:0] disp_count, match_count;

  int checks = 0, failures = 0;
  logic [1:0] hist [0:15];
  logic [6:0] lfsr = 7'h5A;

  always #2.5 clk = ~clk;

  ber_delay_comparator #(.DLY_N(N), .CNT_P(P), .BURST_LEN(BL), .SYNC_THRESH(TH)) u0 (
    .clk(clk), .rst(rst), .tx_nrz(tx_nrz), .tx_strobe(tx_strobe), .rx_nrz(rx_nrz),
    .rx_strobe(rx_strobe), .delay_sel(delay_sel), .tx_bit_count(tx_bit_count),
    .match_clr(match_clr), .bitcnt_clr(bitcnt_clr), .in_sync(in_sync),
    .disp_count(disp_count), .match_count(match_count));

  // columns: delay_sel, link latency, error mask, strobes, expected matches
  localparam int VEC [0:4][0:4] = '{
    '{2, 3, 0,      12, 12},
    '{0, 1, 32'h5,  12, 10},
    '{7, 8, 0,       9,  9},
    '{4, 3, 0,      10,  0},
    '{5, 3, 0,       6,  0}
  };

  function automatic logic [15:0] to_bcd(input int v);
    logic [15:0] r;
    int x;
    x = v % 10000;
    for (int d = 0; d < 4; d++) begin
      r[4*d +: 4] = 4'(x % 10);
      x = x / 10;
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    tx_nrz = 0; tx_strobe = 0; rx_nrz = 0; rx_strobe = 0; tx_bit_count = '0;
    for (int k = 0; k < 16; k++) hist[k] = 2'b00;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // Reference stream with strobe every 'period' cycles; receive side sees it 'lat' cycles later.
  task automatic run_link(input int n, input int period, input int lat, input logic [15:0] errmask);
    int rxk = 0;
    for (int c = 0; c < n * period + lat + 2; c++) begin
      logic s, b;
      @(negedge clk);
      s = (c < n * period) && (c % period == 0);
      b = lfsr[6];
      lfsr = {lfsr[5:0], lfsr[6] ^ lfsr[5]};
      for (int k = 15; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = {s, b};
      tx_strobe = s;
      tx_nrz    = b;
      rx_strobe = hist[lat][1];
      rx_nrz    = hist[lat][0] ^ (hist[lat][1] & errmask[rxk % 16]);
      if (hist[lat][1]) rxk++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    chk("R3", match_count, 16'h0, "reset match_count");
    chk("R3", disp_count, 16'h0, "reset disp_count");
    chk("R3", {30'b0, in_sync, match_clr}, 32'h0, "reset flags");

    // R3: lines empty after reset, so a lone receive strobe finds nothing
    delay_sel = 3'd3; rx_strobe = 1; rx_nrz = 0;
    repeat (6) @(negedge clk);
    rx_strobe = 0;
    @(negedge clk);
    chk("R3", match_count, 16'h0, "no match from cleared line");

    // R1 R2 R4: alignment table
    for (int v = 0; v < 5; v++) begin
      do_reset();
      delay_sel = N'(VEC[v][0]);
      run_link(VEC[v][3], 4, VEC[v][1], 16'(VEC[v][2]));
      @(negedge clk);
      chk(VEC[v][2] != 0 ? "R2" : (VEC[v][4] == 0 ? "R1" : "R4"),
          match_count, to_bcd(VEC[v][4]), $sformatf("vector %0d", v));
    end

    // R4 R5: count to 9999 then wrap
    do_reset();
    delay_sel = 3'd1;
    run_link(9999, 1, 2, 16'h0);
    @(negedge clk);
    chk("R4", match_count, 16'h9999, "count to 9999");
    run_link(1, 1, 2, 16'h0);
    @(negedge clk);
    chk("R5", match_count, 16'h0000, "wrap past 9999");

    // R10: other bit counts ignored
    do_reset();
    delay_sel = 3'd2;
    run_link(4, 4, 3, 16'h0);
    tx_bit_count = 10'd4;
    #1 chk("R10", {31'b0, match_clr | bitcnt_clr}, 32'h0, "no clear at count 4");
    @(negedge clk);
    tx_bit_count = 10'd6;
    #1 chk("R10", {31'b0, match_clr | bitcnt_clr}, 32'h0, "no clear at count 6");
    @(negedge clk);
    chk("R10", {match_count, disp_count}, {16'h0004, 16'h0}, "counts unchanged");

    // R6 R7 R8: burst end with 4 > 3
    tx_bit_count = 10'd5;
    #1 chk("R6", {30'b0, match_clr, bitcnt_clr}, 32'h3, "clear pulse");
    @(negedge clk);
    chk("R6", {30'b0, match_clr, bitcnt_clr}, 32'h0, "clear lasts one cycle");
    chk("R7", disp_count, 16'h0004, "display load");
    chk("R7", match_count, 16'h0, "match cleared");
    chk("R8", {31'b0, in_sync}, 32'h1, "in sync above threshold");
    tx_bit_count = 10'd0;

    // R9: hold between bursts
    run_link(3, 4, 3, 16'h0);
    @(negedge clk);
    chk("R9", {match_count, disp_count}, {16'h0003, 16'h0004}, "display holds");
    chk("R9", {31'b0, in_sync}, 32'h1, "sync holds");

    // R8: count equal to threshold is not in sync
    tx_bit_count = 10'd5;
    @(negedge clk);
    chk("R8", disp_count, 16'h0003, "display second burst");
    chk("R8", {31'b0, in_sync}, 32'h0, "equal to threshold");
    tx_bit_count = 10'd0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule